// File: doc/BRIEF.md
# Multiplexed Bus Machine-Cycle Sequencer

This block is the bus-cycle engine for a processor whose data byte and the low byte of its address travel on one shared 8-bit bus. A client asks for one machine cycle at a time. The available kinds are instruction fetch, memory read, memory write, port read and port write. The block then steps through the bus T-states and drives the upper address lines and the shared bus. The shared bus is driven through an output enable, an output value and an input sampler. The block also drives the address strobe, the active-low read and write strobes, the memory/port select and a two-bit status code. When the cycle ends, the block returns the sampled byte together with a one-cycle completion pulse.

The low address byte is present on the shared bus only during the first T-state. For this reason a small strobe-enabled holding register is part of the block, so the full 16-bit address can be observed in every later T-state. An instruction fetch ends with one extra internal T-state in which the bus is idle. Each clock period is one T-state.

Top module: `mux_bus_seq`

## Requirements
- R1: After reset the block is idle. Both strobes are high, the address strobe is low, the shared bus is not driven, the status code is 00, the select is low, and busy and done are low.
- R2: A cycle begins with exactly one T-state (T1) in which the address strobe is high. In T1 the shared bus is driven with the low address byte and the upper lines carry the high address byte.
- R3: On a read-type cycle (fetch, memory read, port read) the read strobe is low for exactly T2 and T3. The shared bus is not driven by the block from T2 onward.
- R4: On a write-type cycle (memory write, port write) the write strobe is low for exactly T2 and T3, and the read strobe stays high. The shared bus carries the write byte throughout T2 and T3.
- R5: A fetch (kind code 0) occupies 4 T-states. Memory read (1), memory write (2), port read (3) and port write (4) each occupy 3 T-states. Busy is high exactly during those T-states.
- R6: On port cycles (codes 3 and 4) the select is high and the 8-bit port number appears on both the low and the high address byte. On memory cycles the select is low and the 16-bit address is used unchanged.
- R7: The status code {s1,s0} is 11 for a fetch, 10 for memory and port reads, and 01 for memory and port writes. It is held for the whole cycle and is 00 when idle.
- R8: The shared bus is sampled at the clock edge that ends T3, which is also where the read strobe rises. In the clock period after the last T-state, done is high for exactly one cycle and rdData holds the sampled byte.
- R9: The read and write strobes are never low together. The address strobe is never high while either strobe is low.
- R10: A request is taken only while the block is idle. A request raised during a cycle, or one carrying a kind code of 5, 6 or 7, starts nothing.
- R11: From T2 until the end of the cycle, latchedAddr equals the full address of the cycle. The high address byte stays unchanged after T1.
- R12: In T4 of a fetch both strobes are high, the shared bus is not driven, busy stays high and done stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | T-state clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe for a new machine cycle |
| reqKind | input | 3 | Cycle kind: 0 fetch, 1 mem read, 2 mem write, 3 port read, 4 port write |
| reqAddr | input | 16 | Memory address; bits 7:0 give the port number on port cycles |
| reqWrData | input | 8 | Byte to be written on write cycles |
| busy | output | 1 | High while a cycle is in progress |
| done | output | 1 | One-cycle pulse after the final T-state |
| rdData | output | 8 | Byte sampled on the last read-type cycle |
| addrHigh | output | 8 | Upper address lines |
| adOut | output | 8 | Value driven onto the shared bus |
| adOe | output | 1 | Output enable of the shared bus |
| adIn | input | 8 | Value seen on the shared bus |
| ale | output | 1 | Address strobe that marks the low address byte |
| rdN | output | 1 | Active-low read strobe |
| wrN | output | 1 | Active-low write strobe |
| ioM | output | 1 | Port (high) or memory (low) select |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| latchedAddr | output | 16 | Full address rebuilt by the strobe-enabled holding register |

## Verification
The following rules are checked on every clock by the assertions:
- The two strobes never overlap, and the address strobe lasts a single cycle that never coincides with a strobe.
- The block releases the bus while the read strobe is low and drives it while the write strobe is low.
- The port number is mirrored onto both address bytes.
- The high byte, the select and the status stay frozen after T1.
- The holding register keeps the T1 bus value.
- The completion pulse lasts one cycle.

Other behaviour can only be shown by the directed scenarios, which compare values and timing against expectations:
- the exact cycle lengths per kind;
- the status code for each kind;
- the byte sampled at the end of T3;
- the quiet fourth T-state of a fetch;
- the refusal of requests that arrive mid-cycle or carry an undefined code.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

  localparam int KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    KIND_FETCH = 3'd0,
    KIND_MEMRD = 3'd1,
    KIND_MEMWR = 3'd2,
    KIND_IORD  = 3'd3,
    KIND_IOWR  = 3'd4
  } kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_T1,
    ST_T2,
    ST_T3,
    ST_T4
  } tstate_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;
    logic driveAddr;
    logic driveData;
    logic captureIn;
    logic active;
  } strobe_t;

  function automatic logic kindValid(input logic [KIND_W-1:0] k);
    return k <= KIND_IOWR;
  endfunction

  function automatic logic kindIsWrite(input logic [KIND_W-1:0] k);
    return (k == KIND_MEMWR) || (k == KIND_IOWR);
  endfunction

  function automatic logic kindIsIo(input logic [KIND_W-1:0] k);
    return (k == KIND_IORD) || (k == KIND_IOWR);
  endfunction

endpackage

// File: rtl/mbs_ctrl.sv
module mbs_ctrl
  import mbs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [KIND_W-1:0] reqKind,
  output strobe_t           stb,
  output logic              busy,
  output logic              done,
  output logic              ale,
  output logic              rdN,
  output logic              wrN,
  output logic              ioM,
  output logic              s1,
  output logic              s0
);

  tstate_e           state, nextState;
  logic [KIND_W-1:0] kindQ;
  logic              accept;
  logic              lastState;
  logic              strobePhase;
  logic              isWr;

  assign accept      = (state == ST_IDLE) && reqValid && kindValid(reqKind);
  assign isWr        = kindIsWrite(kindQ);
  assign strobePhase = (state == ST_T2) || (state == ST_T3);
  assign lastState   = ((state == ST_T3) && (kindQ != KIND_FETCH)) || (state == ST_T4);

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE: if (accept) nextState = ST_T1;
      ST_T1:   nextState = ST_T2;
      ST_T2:   nextState = ST_T3;
      ST_T3:   nextState = (kindQ == KIND_FETCH) ? ST_T4 : ST_IDLE;
      ST_T4:   nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      kindQ <= KIND_FETCH;
      done  <= 1'b0;
    end else begin
      state <= nextState;
      done  <= lastState;
      if (accept) kindQ <= reqKind;
    end
  end

  assign busy = (state != ST_IDLE);
  assign ale  = (state == ST_T1);
  assign rdN  = !(strobePhase && !isWr);
  assign wrN  = !(strobePhase && isWr);
  assign ioM  = busy && kindIsIo(kindQ);

  always_comb begin
    {s1, s0} = 2'b00;
    if (busy) begin
      if (kindQ == KIND_FETCH) {s1, s0} = 2'b11;
      else if (isWr)           {s1, s0} = 2'b01;
      else                     {s1, s0} = 2'b10;
    end
  end

  always_comb begin
    stb.loadReq   = accept;
    stb.driveAddr = (state == ST_T1);
    stb.driveData = strobePhase && isWr;
    stb.captureIn = (state == ST_T3) && !isWr;
    stb.active    = busy;
  end

endmodule

// File: rtl/mbs_datapath.sv
module mbs_datapath
  import mbs_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [KIND_W-1:0] reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWrData,
  input  logic [DATA_W-1:0] adIn,
  output logic [DATA_W-1:0] addrHigh,
  output logic [DATA_W-1:0] adOut,
  output logic              adOe,
  output logic [DATA_W-1:0] rdData
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [ADDR_W-1:0] addrSel;

  // port cycles mirror the port number onto both bytes
  assign addrSel = kindIsIo(reqKind) ? {reqAddr[DATA_W-1:0], reqAddr[DATA_W-1:0]} : reqAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      dataQ  <= '0;
      rdData <= '0;
    end else begin
      if (stb.loadReq) begin
        addrQ <= addrSel;
        dataQ <= reqWrData;
      end
      if (stb.captureIn) rdData <= adIn;
    end
  end

  assign addrHigh = stb.active ? addrQ[ADDR_W-1:DATA_W] : '0;
  assign adOe     = stb.driveAddr || stb.driveData;

  always_comb begin
    adOut = '0;
    if (stb.driveAddr)      adOut = addrQ[DATA_W-1:0];
    else if (stb.driveData) adOut = dataQ;
  end

endmodule

// File: rtl/mbs_addr_latch.sv
module mbs_addr_latch #(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ale,
  input  logic [DATA_W-1:0] adOut,
  input  logic [DATA_W-1:0] addrHigh,
  output logic [ADDR_W-1:0] latchedAddr
);

  logic [DATA_W-1:0] lowQ;

  always_ff @(posedge clk) begin
    if (!rstN)    lowQ <= '0;
    else if (ale) lowQ <= adOut;
  end

  assign latchedAddr = {addrHigh, lowQ};

endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mbs_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [2:0]  reqKind,
  input  logic [15:0] reqAddr,
  input  logic [7:0]  reqWrData,
  output logic        busy,
  output logic        done,
  output logic [7:0]  rdData,
  output logic [7:0]  addrHigh,
  output logic [7:0]  adOut,
  output logic        adOe,
  input  logic [7:0]  adIn,
  output logic        ale,
  output logic        rdN,
  output logic        wrN,
  output logic        ioM,
  output logic        s1,
  output logic        s0,
  output logic [15:0] latchedAddr
);

  localparam int DATA_W = 8;

  strobe_t stb;

  mbs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .stb(stb), .busy(busy), .done(done), .ale(ale), .rdN(rdN), .wrN(wrN),
    .ioM(ioM), .s1(s1), .s0(s0)
  );

  mbs_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqKind(reqKind), .reqAddr(reqAddr),
    .reqWrData(reqWrData), .adIn(adIn), .addrHigh(addrHigh), .adOut(adOut),
    .adOe(adOe), .rdData(rdData)
  );

  mbs_addr_latch #(.DATA_W(DATA_W)) u_latch (
    .clk(clk), .rstN(rstN), .ale(ale), .adOut(adOut), .addrHigh(addrHigh),
    .latchedAddr(latchedAddr)
  );

endmodule

// File: rtl/mux_bus_seq_chk.sv
module mux_bus_seq_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busy,
  input logic        done,
  input logic [7:0]  addrHigh,
  input logic [7:0]  adOut,
  input logic        adOe,
  input logic        ale,
  input logic        rdN,
  input logic        wrN,
  input logic        ioM,
  input logic        s1,
  input logic        s0,
  input logic [15:0] latchedAddr
);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN)); // R9

  AST_ALE_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> (rdN && wrN && adOe)); // R9

  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> !ale); // R2

  AST_RD_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> !adOe); // R3

  AST_RD_TWO: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdN) |=> !rdN); // R3

  AST_WR_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |-> adOe); // R4

  AST_PORT_MIRROR: assert property (@(posedge clk) disable iff (!rstN)
    (ale && ioM) |-> (adOut == addrHigh)); // R6

  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !ale) |-> $stable({s1, s0, ioM})); // R7

  AST_HIGH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !ale) |-> $stable(addrHigh)); // R11

  AST_LATCH_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ale) |-> (latchedAddr[7:0] == $past(adOut))); // R11

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R8

endmodule

bind mux_bus_seq mux_bus_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .addrHigh(addrHigh),
  .adOut(adOut), .adOe(adOe), .ale(ale), .rdN(rdN), .wrN(wrN), .ioM(ioM),
  .s1(s1), .s0(s0), .latchedAddr(latchedAddr)
);

// File: tb/sim_mux_bus_seq.sv
`timescale 1ns/1ps
module sim_mux_bus_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqKind = 3'd0;
  logic [15:0] reqAddr = 16'h0;
  logic [7:0]  reqWrData = 8'h0;
  logic [7:0]  adIn = 8'h0;
  logic        busy, done, adOe, ale, rdN, wrN, ioM, s1, s0;
  logic [7:0]  rdData, addrHigh, adOut;
  logic [15:0] latchedAddr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  mux_bus_seq u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqAddr(reqAddr), .reqWrData(reqWrData), .busy(busy), .done(done),
    .rdData(rdData), .addrHigh(addrHigh), .adOut(adOut), .adOe(adOe),
    .adIn(adIn), .ale(ale), .rdN(rdN), .wrN(wrN), .ioM(ioM), .s1(s1),
    .s0(s0), .latchedAddr(latchedAddr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // present a request; returns at the negedge inside T1
  task automatic issue(input logic [2:0] k, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqKind = k; reqAddr = a; reqWrData = d;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 strobes", {rdN, wrN, ale, adOe}, 4'b1100);
    chk("R1 status", {s1, s0, ioM, busy, done}, 5'b0);
  endtask

  task automatic t_read(input logic [2:0] k, input logic [15:0] a, input logic [7:0] d);
    logic [15:0] full;
    logic [1:0]  st;
    full = (k == 3'd3) ? {a[7:0], a[7:0]} : a;
    st   = (k == 3'd0) ? 2'b11 : 2'b10;
    issue(k, a, 8'h00);
    // T1
    chk("R2 T1 ale/oe", {ale, adOe, rdN, wrN}, 4'b1111);
    chk("R2 T1 low byte", adOut, full[7:0]);
    chk("R6 T1 high byte", addrHigh, full[15:8]);
    chk("R6 select", ioM, (k == 3'd3));
    chk("R7 status", {s1, s0}, st);
    @(negedge clk);
    // T2
    chk("R3 T2 strobes", {ale, adOe, rdN, wrN}, 4'b0001);
    chk("R11 T2 latched", latchedAddr, full);
    adIn = d;
    @(negedge clk);
    // T3
    chk("R3 T3 strobes", {adOe, rdN, wrN, busy}, 4'b0011);
    chk("R11 T3 latched", latchedAddr, full);
    chk("R7 status held", {s1, s0}, st);
    @(negedge clk);
    adIn = 8'h00;
    if (k == 3'd0) begin
      chk("R12 T4 quiet", {rdN, wrN, adOe, busy, done}, 5'b11010);
      @(negedge clk);
    end
    chk("R5 length end", {busy, rdN}, 2'b01);
    chk("R8 done", done, 1'b1);
    chk("R8 data", rdData, d);
    @(negedge clk);
    chk("R8 single pulse", done, 1'b0);
    chk("R1 idle status", {s1, s0, ioM}, 3'b0);
  endtask

  task automatic t_write(input logic [2:0] k, input logic [15:0] a, input logic [7:0] d);
    logic [15:0] full;
    full = (k == 3'd4) ? {a[7:0], a[7:0]} : a;
    issue(k, a, d);
    chk("R2 T1 addr", {addrHigh, adOut}, full);
    chk("R6 select", ioM, (k == 3'd4));
    chk("R7 status", {s1, s0}, 2'b01);
    @(negedge clk);
    chk("R4 T2 strobes", {adOe, rdN, wrN}, 3'b110);
    chk("R4 T2 data", adOut, d);
    chk("R11 T2 latched", latchedAddr, full);
    @(negedge clk);
    chk("R4 T3 strobes", {adOe, rdN, wrN}, 3'b110);
    chk("R4 T3 data", adOut, d);
    @(negedge clk);
    chk("R5 three states", {busy, done, wrN, adOe}, 4'b0110);
    @(negedge clk);
    chk("R8 single pulse", done, 1'b0);
  endtask

  task automatic t_busy_ignore();
    issue(3'd1, 16'h1234, 8'h00);
    @(negedge clk);
    reqValid = 1'b1; reqKind = 3'd4; reqAddr = 16'h00EE; reqWrData = 8'h55;
    adIn = 8'h3C;
    @(negedge clk);
    chk("R10 mid-cycle addr", addrHigh, 8'h12);
    chk("R10 mid-cycle kind", {ioM, s1, s0}, 3'b010);
    @(negedge clk);
    reqValid = 1'b0;
    chk("R10 done after read", {done, busy}, 2'b10);
    chk("R10 data kept", rdData, 8'h3C);
    @(negedge clk);
    chk("R10 no new cycle", {busy, ale}, 2'b00);
    adIn = 8'h00;
  endtask

  task automatic t_bad_kind();
    for (int k = 5; k < 8; k++) begin
      @(negedge clk);
      reqValid = 1'b1; reqKind = k[2:0]; reqAddr = 16'hBEEF;
      @(negedge clk);
      reqValid = 1'b0;
      chk("R10 bad code", {busy, ale, adOe}, 3'b000);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_read(3'd1, 16'hA55A, 8'hC3);  // memory read
    t_read(3'd0, 16'h8030, 8'h3E);  // fetch
    t_read(3'd3, 16'h7740, 8'h9B);  // port read
    t_write(3'd2, 16'h9001, 8'h5F); // memory write
    t_write(3'd4, 16'h0301, 8'hA6); // port write
    t_busy_ignore();
    t_bad_kind();
    t_read(3'd0, 16'hFFFF, 8'h00);  // fetch at top address
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule